// File: doc/BRIEF.md
# SDLC Receive Frame Controller

This block sits between an SDLC deframer and a shared packet memory. The deframer hands it one-cycle strobes: the start of a frame, each received byte with its data, and the end of a frame. Alongside these comes the output of a CRC16 engine that runs over the same bytes. The controller stores each byte in the receive region of the memory through a single request/acknowledge write port. When a frame that opened with a start strobe closes with a stop strobe, it writes a checksum verdict byte and then a length byte. It then raises a one-cycle interrupt to the CPU.

Bytes are stored in arrival order from the base of the receive region. The stored count includes the two trailing CRC bytes. A frame is good when the CRC value presented at the stop strobe is marked valid and equals the residue expected for the CRC preset in use. The controller drops bytes beyond the buffer capacity and writes an error code as the length instead of a count. A start that arrives in the middle of a frame discards the partial frame. Loss of the bit clock aborts everything without status.

The deframer delivers bytes at the serial bit rate, so two bytes are always many system clocks apart. One memory write and the two status writes each finish well within one byte time. A byte strobe that arrives while a byte write is still outstanding is not captured.

Top module: `sdlc_rx_frame_ctrl`

## Requirements
- R1: Byte k of a frame (k counted from 0 after the start strobe) is written to address 0x100+k. The write request stays high with stable address and data until it is acknowledged (a write completes on a cycle with mem_req and mem_ack both high).
- R2: At most 254 bytes per frame are written (addresses 0x100 to 0x1FD). Further bytes of the same frame cause no memory write.
- R3: When a frame carried more than 254 bytes, the length byte written to 0x1FF is 0xFF.
- R4: At the stop strobe the checksum verdict is written to 0x1FE. The verdict is 0xFF when crc_valid is high and crc_value equals the configured residue (default 0x0000), and 0x00 otherwise.
- R5: For a frame of at most 254 bytes, the length byte at 0x1FF equals the number of bytes received, including the CRC bytes. It is written after the checksum verdict has been acknowledged.
- R6: A stop strobe with no frame open causes no memory write and no interrupt.
- R7: A start strobe inside an open frame discards the partial frame. The next byte is written to 0x100, and the length counts only bytes after the new start.
- R8: While bclk_ok is low, mem_req and rx_irq are low in the following cycle. An aborted frame writes no status and raises no interrupt.
- R9: rx_irq is high for exactly one cycle, in the cycle after the length write completes, once per complete frame.
- R10: A start strobe in the same cycle as a stop strobe, or during the status writes, opens a new frame. The new frame is collected after the previous status completes, with its first byte at 0x100.
- R11: A stop strobe that arrives while a byte write is outstanding is honoured after that write completes, and the length includes that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_ok | input | 1 | Serial bit clock present |
| frm_start | input | 1 | Frame start strobe from deframer |
| frm_stop | input | 1 | Frame stop strobe from deframer |
| frm_valid | input | 1 | Received byte strobe |
| frm_data | input | 8 | Received byte |
| crc_valid | input | 1 | CRC engine result is current |
| crc_value | input | 16 | CRC accumulator over frame bytes |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 9 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| mem_ack | input | 1 | Memory write acknowledge |
| rx_irq | output | 1 | One-cycle frame-received interrupt |

## Verification
A closing flag that doubles as the next opening flag makes the stop and start strobes land in the same cycle. The bench provokes this directly and expects two separate status pairs and two interrupts, with the second frame's bytes again at the base address. The other collision is a stop strobe in the cycle right after a byte, while that byte's write still waits for its acknowledge. Random acknowledge latency makes the stop fall before, on, or after the completing cycle, and the bench judges the case by the length byte and the stored bytes.

// File: rtl/sdlc_rxc_pkg.sv
package sdlc_rxc_pkg;

    localparam int SDLC_AW    = 9;
    localparam int SDLC_DW    = 8;
    localparam int SDLC_CRC_W = 16;

    typedef enum logic [2:0] {
        RS_IDLE,
        RS_COLLECT,
        RS_BYTE,
        RS_CRC,
        RS_LEN
    } rx_state_e;

    typedef struct packed {
        logic stop_pend;
        logic start_pend;
    } rx_flags_t;

    function automatic logic [SDLC_DW-1:0] verdict_code(input logic ok);
        return ok ? {SDLC_DW{1'b1}} : {SDLC_DW{1'b0}};
    endfunction

endpackage

// File: rtl/sdlc_rxc_len_track.sv
module sdlc_rxc_len_track #(
    parameter int LIMIT = 254,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          accept,
    output logic [CW-1:0] cnt,
    output logic          ovf,
    output logic          room
);
    assign room = (cnt < CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (accept) begin
            if (room) cnt <= cnt + 1'b1;
            else      ovf <= 1'b1;
        end
    end
endmodule

// File: rtl/sdlc_rxc_crc_judge.sv
module sdlc_rxc_crc_judge #(
    parameter int                CRC_W   = 16,
    parameter logic [CRC_W-1:0]  RESIDUE = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             capture,
    input  logic             crc_valid,
    input  logic [CRC_W-1:0] crc_value,
    output logic             ok_now,
    output logic             ok_held
);
    assign ok_now = crc_valid && (crc_value == RESIDUE);

    always_ff @(posedge clk) begin
        if (rst)          ok_held <= 1'b0;
        else if (capture) ok_held <= ok_now;
    end
endmodule

// File: rtl/sdlc_rxc_wr_port.sv
module sdlc_rxc_wr_port #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          abort,
    input  logic          issue,
    input  logic [AW-1:0] issue_addr,
    input  logic [DW-1:0] issue_data,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          done
);
    assign done = mem_req && mem_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req   <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else if (abort) begin
            mem_req   <= 1'b0;
        end else if (issue) begin
            mem_req   <= 1'b1;
            mem_addr  <= issue_addr;
            mem_wdata <= issue_data;
        end else if (done) begin
            mem_req   <= 1'b0;
        end
    end
endmodule

// File: rtl/sdlc_rx_frame_ctrl.sv
module sdlc_rx_frame_ctrl
    import sdlc_rxc_pkg::*;
#(
    parameter int                    AW          = SDLC_AW,
    parameter int                    DW          = SDLC_DW,
    parameter int                    CRC_W       = SDLC_CRC_W,
    parameter logic [AW-1:0]         RX_BASE     = 9'h100,
    parameter int                    BUF_BYTES   = 254,
    parameter logic [CRC_W-1:0]      CRC_RESIDUE = '0,
    parameter logic [DW-1:0]         ERR_LEN     = 8'hFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk_ok,
    input  logic             frm_start,
    input  logic             frm_stop,
    input  logic             frm_valid,
    input  logic [DW-1:0]    frm_data,
    input  logic             crc_valid,
    input  logic [CRC_W-1:0] crc_value,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    output logic             rx_irq
);
    localparam int            CNT_W    = $clog2(BUF_BYTES + 1);
    localparam logic [AW-1:0] CRC_ADDR = RX_BASE + AW'(BUF_BYTES);
    localparam logic [AW-1:0] LEN_ADDR = RX_BASE + AW'(BUF_BYTES + 1);

    rx_state_e       st_q, st_n;
    rx_flags_t       flg_q, flg_n;
    logic            irq_q, irq_n;

    logic            trk_clr, trk_acc, trk_ovf, trk_room;
    logic [CNT_W-1:0] trk_cnt;
    logic            capt, ok_now, ok_held;
    logic            issue, wr_done;
    logic [AW-1:0]   iss_addr;
    logic [DW-1:0]   iss_data;
    logic [DW-1:0]   len_code;
    logic [DW-1:0]   verdict_now, verdict_held;

    sdlc_rxc_len_track #(.LIMIT(BUF_BYTES), .CW(CNT_W)) u_len (
        .clk(clk), .rst(rst), .clr(trk_clr), .accept(trk_acc),
        .cnt(trk_cnt), .ovf(trk_ovf), .room(trk_room)
    );

    sdlc_rxc_crc_judge #(.CRC_W(CRC_W), .RESIDUE(CRC_RESIDUE)) u_judge (
        .clk(clk), .rst(rst), .capture(capt), .crc_valid(crc_valid),
        .crc_value(crc_value), .ok_now(ok_now), .ok_held(ok_held)
    );

    sdlc_rxc_wr_port #(.AW(AW), .DW(DW)) u_port (
        .clk(clk), .rst(rst), .abort(!bclk_ok), .issue(issue),
        .issue_addr(iss_addr), .issue_data(iss_data), .mem_ack(mem_ack),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(wr_done)
    );

    assign len_code     = trk_ovf ? ERR_LEN : DW'(trk_cnt);
    assign verdict_now  = ok_now  ? {DW{1'b1}} : {DW{1'b0}};
    assign verdict_held = ok_held ? {DW{1'b1}} : {DW{1'b0}};

    always_comb begin
        st_n     = st_q;
        flg_n    = flg_q;
        irq_n    = 1'b0;
        issue    = 1'b0;
        iss_addr = RX_BASE;
        iss_data = '0;
        trk_clr  = 1'b0;
        trk_acc  = 1'b0;
        capt     = 1'b0;
        unique case (st_q)
            RS_IDLE: begin
                if (frm_start) begin
                    st_n    = RS_COLLECT;
                    trk_clr = 1'b1;
                    flg_n   = '0;
                end
            end
            RS_COLLECT: begin
                if (frm_stop || flg_q.stop_pend) begin
                    // close the frame; a coincident start opens the next one later
                    capt             = frm_stop;
                    issue            = 1'b1;
                    iss_addr         = CRC_ADDR;
                    iss_data         = frm_stop ? verdict_now : verdict_held;
                    flg_n.stop_pend  = 1'b0;
                    flg_n.start_pend = flg_q.start_pend | frm_start;
                    st_n             = RS_CRC;
                end else if (frm_start) begin
                    trk_clr = 1'b1;
                end else if (frm_valid) begin
                    trk_acc = 1'b1;
                    if (trk_room) begin
                        issue    = 1'b1;
                        iss_addr = RX_BASE + AW'(trk_cnt);
                        iss_data = frm_data;
                        st_n     = RS_BYTE;
                    end
                end
            end
            RS_BYTE: begin
                if (frm_stop) begin
                    capt             = 1'b1;
                    flg_n.stop_pend  = 1'b1;
                    flg_n.start_pend = flg_q.start_pend | frm_start;
                end else if (frm_start) begin
                    if (flg_q.stop_pend) flg_n.start_pend = 1'b1;
                    else                 trk_clr = 1'b1;
                end
                if (wr_done) st_n = RS_COLLECT;
            end
            RS_CRC: begin
                flg_n.start_pend = flg_q.start_pend | frm_start;
                if (wr_done) begin
                    issue    = 1'b1;
                    iss_addr = LEN_ADDR;
                    iss_data = len_code;
                    st_n     = RS_LEN;
                end
            end
            RS_LEN: begin
                flg_n.start_pend = flg_q.start_pend | frm_start;
                if (wr_done) begin
                    irq_n = 1'b1;
                    flg_n = '0;
                    if (flg_q.start_pend || frm_start) begin
                        st_n    = RS_COLLECT;
                        trk_clr = 1'b1;
                    end else begin
                        st_n = RS_IDLE;
                    end
                end
            end
            default: st_n = RS_IDLE;
        endcase
        if (!bclk_ok) begin
            st_n  = RS_IDLE;
            flg_n = '0;
            issue = 1'b0;
            irq_n = 1'b0;
            capt  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= RS_IDLE;
            flg_q <= '0;
            irq_q <= 1'b0;
        end else begin
            st_q  <= st_n;
            flg_q <= flg_n;
            irq_q <= irq_n;
        end
    end

    assign rx_irq = irq_q;

endmodule

// File: rtl/sdlc_rxc_checker.sv
module sdlc_rxc_checker #(
    parameter int            AW        = 9,
    parameter int            DW        = 8,
    parameter logic [AW-1:0] RX_BASE   = 9'h100,
    parameter int            BUF_BYTES = 254
) (
    input logic          clk,
    input logic          rst,
    input logic          bclk_ok,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic          rx_irq
);
    localparam logic [AW-1:0] CRC_ADDR = RX_BASE + AW'(BUF_BYTES);
    localparam logic [AW-1:0] LEN_ADDR = RX_BASE + AW'(BUF_BYTES + 1);

    p_req_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && bclk_ok) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

    p_addr_window_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr >= RX_BASE && mem_addr <= LEN_ADDR));

    p_verdict_code_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_addr == CRC_ADDR) |-> (mem_wdata == {DW{1'b1}} || mem_wdata == {DW{1'b0}}));

    p_clock_loss_r8: assert property (@(posedge clk) disable iff (rst)
        !bclk_ok |=> (!mem_req && !rx_irq));

    p_irq_after_len_r9: assert property (@(posedge clk) disable iff (rst)
        rx_irq |-> $past(mem_req && mem_ack && mem_addr == LEN_ADDR));

    p_irq_single_r9: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);
endmodule

bind sdlc_rx_frame_ctrl sdlc_rxc_checker #(
    .AW(AW), .DW(DW), .RX_BASE(RX_BASE), .BUF_BYTES(BUF_BYTES)
) chk_i (
    .clk(clk), .rst(rst), .bclk_ok(bclk_ok), .mem_req(mem_req),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .rx_irq(rx_irq)
);

// File: tb/sdlc_rx_frame_ctrl_tb_top.sv
`timescale 1ns/1ps
module sdlc_rx_frame_ctrl_tb_top;
    localparam int          GAP = 12;
    localparam logic [15:0] RES = 16'h0000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, bclk_ok, frm_start, frm_stop, frm_valid, crc_valid;
    logic [7:0]  frm_data;
    logic [15:0] crc_value;
    logic        mem_req, mem_ack, rx_irq;
    logic [8:0]  mem_addr;
    logic [7:0]  mem_wdata;

    sdlc_rx_frame_ctrl dut_i (
        .clk(clk), .rst(rst), .bclk_ok(bclk_ok), .frm_start(frm_start),
        .frm_stop(frm_stop), .frm_valid(frm_valid), .frm_data(frm_data),
        .crc_valid(crc_valid), .crc_value(crc_value), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .rx_irq(rx_irq)
    );

    int checks = 0, errors = 0;
    logic [7:0] img  [0:511];
    logic [7:0] sent [0:511];
    int wr_total = 0, irq_total = 0, len_n = 0, vrd_n = 0;
    int len_hist [0:255];
    int lat = 0;

    // memory model: acknowledge after 0..2 extra cycles
    always @(negedge clk) begin
        if (rst) begin
            mem_ack = 1'b0; lat = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0; lat = $urandom % 3;
        end else if (mem_req) begin
            if (lat == 0) mem_ack = 1'b1;
            else          lat--;
        end
    end

    always @(posedge clk) begin
        if (!rst && mem_req && mem_ack) begin
            img[mem_addr] = mem_wdata;
            wr_total++;
            if (mem_addr == 9'h1FF) begin len_hist[len_n % 256] = mem_wdata; len_n++; end
            if (mem_addr == 9'h1FE) vrd_n++;
        end
        if (!rst && rx_irq) irq_total++;
    end

    function automatic int exp_len(input int n);
        return (n > 254) ? 255 : n;
    endfunction
    function automatic int exp_verdict(input bit good);
        return good ? 255 : 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic put_start();
        frm_start = 1'b1; @(negedge clk); frm_start = 1'b0;
    endtask
    task automatic put_byte(input int idx);
        logic [7:0] d;
        d = 8'($urandom);
        sent[idx] = d;
        frm_valid = 1'b1; frm_data = d; @(negedge clk); frm_valid = 1'b0;
    endtask
    task automatic set_crc(input bit good);
        int pick;
        pick = $urandom % 2;
        if (good) begin crc_valid = 1'b1; crc_value = RES; end
        else if (pick == 0) begin crc_valid = 1'b1; crc_value = RES ^ 16'h1D0F; end
        else begin crc_valid = 1'b0; crc_value = RES; end
    endtask
    task automatic put_stop(input bit good, input bit with_start);
        set_crc(good);
        frm_stop = 1'b1; frm_start = with_start;
        @(negedge clk);
        frm_stop = 1'b0; frm_start = 1'b0;
    endtask
    task automatic wait_irqs(input int target);
        for (int i = 0; i < 400 && irq_total < target; i++) @(negedge clk);
        tick(3);
    endtask
    task automatic scrub();
        for (int a = 9'h100; a < 9'h200; a++) img[a] = 8'hEE;
    endtask
    task automatic check_bytes(input string req, input int n);
        int bad;
        int lim;
        bad = -1;
        lim = (n > 254) ? 254 : n;
        for (int i = 0; i < lim; i++)
            if (bad < 0 && img[9'h100 + i] !== sent[i]) bad = i;
        if (bad < 0) check(req, 1, 1);
        else check(req, int'(img[9'h100 + bad]), int'(sent[bad]));
    endtask

    task automatic run_frame(input int n, input bit good, input int stop_gap, input string tag);
        int w0, i0;
        scrub();
        w0 = wr_total; i0 = irq_total;
        put_start();
        for (int i = 0; i < n; i++) begin tick(GAP - 1); put_byte(i); end
        tick(stop_gap - 1);
        put_stop(good, 1'b0);
        wait_irqs(i0 + 1);
        check_bytes({tag, " R1 bytes"}, n);
        check({tag, " R2 write count"}, wr_total - w0, ((n > 254) ? 254 : n) + 2);
        check({tag, " R4 verdict"}, int'(img[9'h1FE]), exp_verdict(good));
        check({tag, (n > 254) ? " R3 overflow length" : " R5 length"}, int'(img[9'h1FF]), exp_len(n));
        check({tag, " R9 one irq"}, irq_total - i0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0, i0, l0, v0, nb, req_seen;
        void'($urandom(32'd7));
        rst = 1'b1; bclk_ok = 1'b1; frm_start = 0; frm_stop = 0; frm_valid = 0;
        frm_data = 0; crc_valid = 0; crc_value = 0;
        tick(5);
        rst = 1'b0;
        tick(1);
        check("R9 reset irq low", int'(rx_irq), 0);
        check("R1 reset req low", int'(mem_req), 0);

        // R6: stop with no frame open
        w0 = wr_total; i0 = irq_total;
        put_stop(1'b1, 1'b0);
        tick(10);
        check("R6 idle stop writes", wr_total - w0, 0);
        check("R6 idle stop irq", irq_total - i0, 0);

        // directed sizes
        run_frame(0, 1'b1, GAP, "empty");
        run_frame(2, 1'b0, GAP, "short");
        run_frame(254, 1'b1, GAP, "full");
        run_frame(255, 1'b1, GAP, "over1");
        run_frame(300, 1'b0, GAP, "over");

        // R11: stop right after the last byte, byte write still pending
        run_frame(5, 1'b1, 1, "R11 stop-pending");

        // R7: restart in mid-frame
        scrub();
        l0 = len_n; i0 = irq_total;
        put_start();
        for (int i = 0; i < 5; i++) begin tick(GAP - 1); put_byte(i); end
        tick(GAP - 1);
        put_start();
        for (int i = 0; i < 3; i++) begin tick(GAP - 1); put_byte(i); end
        tick(GAP - 1);
        put_stop(1'b1, 1'b0);
        wait_irqs(i0 + 1);
        check_bytes("R7 restart bytes", 3);
        check("R7 restart length", int'(img[9'h1FF]), 3);

        // R10: stop and start in the same cycle
        i0 = irq_total; l0 = len_n;
        put_start();
        for (int i = 0; i < 4; i++) begin tick(GAP - 1); put_byte(i); end
        tick(GAP - 1);
        put_stop(1'b0, 1'b1);
        scrub();
        nb = 6;
        for (int i = 0; i < nb; i++) begin tick(GAP - 1); put_byte(i); end
        tick(GAP - 1);
        put_stop(1'b1, 1'b0);
        wait_irqs(i0 + 2);
        check("R10 two irqs", irq_total - i0, 2);
        check("R10 first length", len_hist[l0 % 256], 4);
        check("R10 second length", len_hist[(l0 + 1) % 256], nb);
        check_bytes("R10 second bytes", nb);
        check("R10 second verdict", int'(img[9'h1FE]), exp_verdict(1'b1));

        // R8: bit clock lost mid-frame
        i0 = irq_total; l0 = len_n; v0 = vrd_n;
        put_start();
        for (int i = 0; i < 3; i++) begin tick(GAP - 1); put_byte(i); end
        tick(GAP - 1);
        put_byte(3);
        bclk_ok = 1'b0;
        req_seen = 0;
        for (int i = 0; i < 6; i++) begin @(negedge clk); if (mem_req) req_seen++; end
        check("R8 req low without clock", req_seen, 0);
        bclk_ok = 1'b1;
        tick(4);
        put_stop(1'b1, 1'b0);
        tick(20);
        check("R8 no length write", len_n - l0, 0);
        check("R8 no verdict write", vrd_n - v0, 0);
        check("R8 no irq", irq_total - i0, 0);
        run_frame(3, 1'b1, GAP, "R8 recovery");

        // random frames
        for (int f = 0; f < 16; f++) begin
            run_frame($urandom % 24, 1'($urandom % 2), 1 + ($urandom % 4), "rand");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule